// File: doc/BRIEF.md
# Serial Port Status Change Register

This block holds the status word for one serial port channel. It gathers conditions from a UART receiver and transmitter and shows them in one 32-bit word on a simple register bus. Some of the bits are sticky event flags that software clears by writing zero to them. One flag clears itself when the receiver delivers a normal frame. The remaining bits are live views of the transmit FIFO, the shift register and the CTS pin. The receiver and transmitter report to the block through single-cycle event pulses and level inputs.

A second word at its own address holds a per-bit interrupt enable mask. The interrupt request output is high whenever any status bit is set and its enable bit is also set. Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high. Any address that is not one of the two decoded word addresses reads as zero, and writes to it are ignored.

Top module: `uart_stat_reg`

## Requirements
- R1: The status word is read at address STAT_ADDR (default 0x0C) and is 32 bits wide. Bits 31 down to 6 always read as zero.
- R2: Bit 5 (overrun) becomes 1 on the clock edge after an `ev_overrun` pulse. It becomes 0 only when a write to STAT_ADDR carries 0 in bit 5. Its reset value is 0.
- R3: Bit 0 (sticky break) becomes 1 on the clock edge after an `ev_break` pulse. It becomes 0 only when a write to STAT_ADDR carries 0 in bit 0. Its reset value is 0.
- R4: Bit 3 (break state) becomes 1 after `ev_break` and becomes 0 after an `ev_frame_ok` pulse. If both pulses arrive in the same cycle, the bit is 1. Software writes do not change it. Its reset value is 0.
- R5: Bit 4 shows the `cts_pin` level after two synchronizer stages. A change on the pin is still absent after one clock edge and appears after the second edge.
- R6: Bit 2 (transmit ready) is `txf_free` registered once. Its reset value is 1.
- R7: Bit 1 (all sent) is `txf_empty` AND `tx_shift_idle`, registered once. Its reset value is 1.
- R8: Writing 1 to bit 5 or bit 0 leaves them unchanged. Writes to bits 4 through 1 and to bits 31 through 6 have no effect on the value read back.
- R9: If a set event and a clearing write reach a sticky bit in the same cycle, the bit ends up 1.
- R10: The enable mask is read and written at MASK_ADDR (default 0x10). Only bits 5 to 0 are stored, in the same positions as the status bits. The upper bits read as zero, and the mask resets to zero.
- R11: `irq` is 1 exactly when the AND of the status bits 5 to 0 and the mask is nonzero.
- R12: Reads at any address other than STAT_ADDR and MASK_ADDR return zero, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from address |
| ev_overrun | input | 1 | Receive overrun event pulse |
| ev_break | input | 1 | Break detected event pulse |
| ev_frame_ok | input | 1 | Non-break frame received pulse |
| cts_pin | input | 1 | Asynchronous CTS pin level |
| txf_free | input | 1 | Transmit FIFO has at least one free stage |
| txf_empty | input | 1 | Transmit FIFO is empty |
| tx_shift_idle | input | 1 | Transmit shift registers are empty |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes all ones and then selective zeros to the status word, and this exposes three kinds of faults. A design that clears on written ones, or one that lets writes reach the live bits, shows changed bits after the all-ones write. A design that gives the clear priority over the event loses the flag when the event and the clearing write fall in the same cycle. The break-state bit is driven with a lone break, a lone normal frame and both together. This catches a flag that ignores the normal frame, and a flag that lets the frame win. The CTS bit is sampled after one edge and again after two, so a missing or extra synchronizer stage shows up. All 64 mask values are swept under two different status patterns, and all 256 addresses are read. This finds a wrong OR term in the interrupt, a wrong mask width, and an address decode that aliases.

// File: rtl/uscr_pkg.sv
`timescale 1ns/1ps
package uscr_pkg;
   localparam int BIT_BRK_STICKY = 0;
   localparam int BIT_TX_DONE    = 1;
   localparam int BIT_TX_RDY     = 2;
   localparam int BIT_BRK_LIVE   = 3;
   localparam int BIT_CTS        = 4;
   localparam int BIT_OVR        = 5;
   localparam int NUM_BITS       = 6;

   typedef enum logic {
      FLAG_W0C  = 1'b0,
      FLAG_SELF = 1'b1
   } flag_mode_e;
endpackage

// File: rtl/uscr_sync.sv
`timescale 1ns/1ps
// Register chain used both as a pin synchronizer and as a single retiming stage.
module uscr_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("uscr_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= RESET_VAL;
         else        chain <= d_i;
      end
   end else begin : g_multi
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= {STAGES{RESET_VAL}};
         else        chain <= {chain[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain[STAGES-1];

   // R5, R6, R7: the first stage captures the input on every edge after reset
   p_first_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> chain[0] == $past(d_i));
endmodule

// File: rtl/uscr_flag.sv
`timescale 1ns/1ps
// One status flag: set by an event pulse, cleared by a request; set has priority.
module uscr_flag
   import uscr_pkg::*;
#(
   parameter flag_mode_e MODE      = FLAG_W0C,
   parameter logic       RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     q_q <= RESET_VAL;
      else if (set_i) q_q <= 1'b1;
      else if (clr_i) q_q <= 1'b0;
   end

   assign q_o = q_q;

   // R9: an event always leaves the flag set, whatever the clear request did
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_q);

   if (MODE == FLAG_W0C) begin : g_w0c
      // R2, R3: a sticky flag falls only after a software clear request
      p_sticky_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
         q_q && !clr_i |=> q_q);
   end else begin : g_self
      // R4: the live break flag falls only after a normal frame
      p_self_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
         q_q && !clr_i |=> q_q);
   end
endmodule

// File: rtl/uscr_irq.sv
`timescale 1ns/1ps
// Enable mask register and gated OR reduction into the interrupt request.
module uscr_irq #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   input  logic [N-1:0] status_i,
   output logic [N-1:0] mask_o,
   output logic         irq_o
);
   if (N < 1) begin : g_bad_n
      $error("uscr_irq: N must be at least 1");
   end

   logic [N-1:0] mask_q;
   logic [N-1:0] gated;

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_q <= '0;
      else if (wr_i) mask_q <= wdata_i;
   end

   for (genvar i = 0; i < N; i++) begin : g_gate
      assign gated[i] = status_i[i] & mask_q[i];
   end

   assign irq_o  = |gated;
   assign mask_o = mask_q;

   // R10: a mask write is stored on the following edge
   p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> mask_q == $past(wdata_i));
   // R11: with every enable off the request stays low
   p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q == '0 |-> !irq_o);
endmodule

// File: rtl/uart_stat_reg.sv
`timescale 1ns/1ps
module uart_stat_reg
   import uscr_pkg::*;
#(
   parameter int              ADDR_W      = 8,
   parameter int              DATA_W      = 32,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0C,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h10,
   parameter int              SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_overrun,
   input  logic              ev_break,
   input  logic              ev_frame_ok,
   input  logic              cts_pin,
   input  logic              txf_free,
   input  logic              txf_empty,
   input  logic              tx_shift_idle,
   output logic              irq
);
   localparam int PAD_W = DATA_W - NUM_BITS;

   if (DATA_W < NUM_BITS) begin : g_bad_width
      $error("uart_stat_reg: DATA_W too small for status bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_stat_reg: CTS synchronizer needs two or more stages");
   end
   if (STAT_ADDR == MASK_ADDR) begin : g_bad_addr
      $error("uart_stat_reg: status and mask addresses collide");
   end
   if (STAT_ADDR[1:0] != 2'b00 || MASK_ADDR[1:0] != 2'b00) begin : g_bad_align
      $error("uart_stat_reg: addresses must be word aligned");
   end

   logic sel_stat, sel_mask, wr_stat, wr_mask;
   logic ovr_q, brk_sticky_q, brk_live_q, cts_q, tx_rdy_q, tx_done_q;
   logic [NUM_BITS-1:0] stat_vec;
   logic [NUM_BITS-1:0] mask_vec;

   assign sel_stat = (bus_addr == STAT_ADDR);
   assign sel_mask = (bus_addr == MASK_ADDR);
   assign wr_stat  = bus_wr && sel_stat;
   assign wr_mask  = bus_wr && sel_mask;

   uscr_flag #(.MODE(FLAG_W0C), .RESET_VAL(1'b0)) u_ovr (
      .clk(clk), .rst_n(rst_n), .set_i(ev_overrun),
      .clr_i(wr_stat && !bus_wdata[BIT_OVR]), .q_o(ovr_q));

   uscr_flag #(.MODE(FLAG_W0C), .RESET_VAL(1'b0)) u_brk_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(ev_break),
      .clr_i(wr_stat && !bus_wdata[BIT_BRK_STICKY]), .q_o(brk_sticky_q));

   uscr_flag #(.MODE(FLAG_SELF), .RESET_VAL(1'b0)) u_brk_live (
      .clk(clk), .rst_n(rst_n), .set_i(ev_break),
      .clr_i(ev_frame_ok), .q_o(brk_live_q));

   uscr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_cts (
      .clk(clk), .rst_n(rst_n), .d_i(cts_pin), .q_o(cts_q));

   uscr_sync #(.STAGES(1), .RESET_VAL(1'b1)) u_tx_rdy (
      .clk(clk), .rst_n(rst_n), .d_i(txf_free), .q_o(tx_rdy_q));

   uscr_sync #(.STAGES(1), .RESET_VAL(1'b1)) u_tx_done (
      .clk(clk), .rst_n(rst_n), .d_i(txf_empty & tx_shift_idle), .q_o(tx_done_q));

   always_comb begin
      stat_vec                 = '0;
      stat_vec[BIT_OVR]        = ovr_q;
      stat_vec[BIT_CTS]        = cts_q;
      stat_vec[BIT_BRK_LIVE]   = brk_live_q;
      stat_vec[BIT_TX_RDY]     = tx_rdy_q;
      stat_vec[BIT_TX_DONE]    = tx_done_q;
      stat_vec[BIT_BRK_STICKY] = brk_sticky_q;
   end

   uscr_irq #(.N(NUM_BITS)) u_irq (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_mask),
      .wdata_i(bus_wdata[NUM_BITS-1:0]), .status_i(stat_vec),
      .mask_o(mask_vec), .irq_o(irq));

   always_comb begin
      if (sel_stat)      bus_rdata = {{PAD_W{1'b0}}, stat_vec};
      else if (sel_mask) bus_rdata = {{PAD_W{1'b0}}, mask_vec};
      else               bus_rdata = '0;
   end

   // R12: undecoded addresses read as zero
   p_other_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_stat && !sel_mask |-> bus_rdata == '0);
   // R8: a status write with ones in the sticky positions never drops them
   p_w1_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat && bus_wdata[BIT_OVR] && ovr_q |=> ovr_q);
   // R2: overrun event shows up on the next edge
   p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_overrun |=> ovr_q);
   // R4: a lone normal frame clears the live break flag
   p_brk_live_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame_ok && !ev_break |=> !brk_live_q);
endmodule

// File: tb/sim_uart_stat_reg.sv
`timescale 1ns/1ps
module sim_uart_stat_reg;
   localparam logic [7:0] STAT = 8'h0C;
   localparam logic [7:0] MASK = 8'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ev_overrun = 1'b0, ev_break = 1'b0, ev_frame_ok = 1'b0;
   logic        cts_pin = 1'b0, txf_free = 1'b1, txf_empty = 1'b1, tx_shift_idle = 1'b1;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   uart_stat_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_overrun(ev_overrun),
      .ev_break(ev_break), .ev_frame_ok(ev_frame_ok), .cts_pin(cts_pin),
      .txf_free(txf_free), .txf_empty(txf_empty), .tx_shift_idle(tx_shift_idle),
      .irq(irq));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      tick();
      bus_wr    = 1'b0;
   endtask

   task automatic chk_stat(input string req, input logic [31:0] exp);
      logic [31:0] v;
      rd(STAT, v);
      chk(req, v, exp);
   endtask

   task automatic pulse_ovr();
      ev_overrun = 1'b1; tick(); ev_overrun = 1'b0;
   endtask

   task automatic pulse_brk();
      ev_break = 1'b1; tick(); ev_break = 1'b0;
   endtask

   task automatic pulse_frm();
      ev_frame_ok = 1'b1; tick(); ev_frame_ok = 1'b0;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic mask_sweep(input logic [5:0] st);
      logic [31:0] v;
      for (int m = 0; m < 64; m++) begin
         wr(MASK, 32'(m));
         rd(MASK, v);
         chk("R10 mask readback", v, 32'(m));
         chk("R11 irq", {31'b0, irq}, {31'b0, |(st & 6'(m))});
      end
   endtask

   initial begin
      #800000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [31:0] v;
      tick(); tick();
      rst_n = 1'b1;
      #0.5;
      // R1 R2 R3 R4 R6 R7: reset state
      chk_stat("R6 R7 reset value", 32'h06);
      rd(MASK, v);
      chk("R10 mask reset", v, 32'h0);
      chk("R11 irq reset", {31'b0, irq}, 32'h0);

      // R6 R7: all transmit input combinations
      for (int i = 0; i < 8; i++) begin
         txf_free = i[0]; txf_empty = i[1]; tx_shift_idle = i[2];
         tick();
         rd(STAT, v);
         chk("R6 R7 tx bits", v & 32'h06, {29'b0, i[0], i[1] & i[2], 1'b0});
      end
      txf_free = 1'b1; txf_empty = 1'b1; tx_shift_idle = 1'b1;
      tick();

      // R5: two-stage CTS synchronizer
      cts_pin = 1'b1; tick();
      chk_stat("R5 cts after one edge", 32'h06);
      tick();
      chk_stat("R5 cts after two edges", 32'h16);
      cts_pin = 1'b0; tick(); tick();
      chk_stat("R5 cts low", 32'h06);

      // R2 R8: overrun sticky, write ones ignored, write zero clears
      pulse_ovr();
      chk_stat("R2 overrun set", 32'h26);
      wr(STAT, 32'hFFFF_FFFF);
      chk_stat("R8 write ones no effect", 32'h26);
      rd(STAT, v);
      chk("R1 reserved bits zero", v & 32'hFFFF_FFC0, 32'h0);
      wr(STAT, 32'hFFFF_FFDF);
      chk_stat("R2 overrun cleared", 32'h06);

      // R3 R4: break sticky and break live
      pulse_brk();
      chk_stat("R3 R4 break set", 32'h0F);
      wr(STAT, 32'hFFFF_FFF7);
      chk_stat("R4 R8 live break ignores write", 32'h0F);
      pulse_frm();
      chk_stat("R4 frame clears live break", 32'h07);
      wr(STAT, 32'hFFFF_FFFE);
      chk_stat("R3 sticky break cleared", 32'h06);

      // R9: set beats clear; R4: break beats frame
      ev_overrun = 1'b1;
      wr(STAT, 32'h0);
      ev_overrun = 1'b0;
      chk_stat("R9 set wins over clear", 32'h26);
      ev_break = 1'b1; ev_frame_ok = 1'b1; tick();
      ev_break = 1'b0; ev_frame_ok = 1'b0;
      chk_stat("R4 break wins over frame", 32'h2F);
      pulse_frm();
      wr(STAT, 32'h0);
      chk_stat("R2 R3 cleared", 32'h06);

      // R12: writes elsewhere do nothing, reads elsewhere are zero
      pulse_ovr();
      wr(8'h08, 32'h0);
      chk_stat("R12 write elsewhere ignored", 32'h26);
      wr(STAT, 32'h0);
      for (int a = 0; a < 256; a++) begin
         if (a != int'(STAT) && a != int'(MASK)) begin
            rd(8'(a), v);
            chk("R12 undecoded read", v, 32'h0);
         end
      end

      // R10: only six mask bits stored
      wr(MASK, 32'hFFFF_FFFF);
      rd(MASK, v);
      chk("R10 mask width", v, 32'h3F);

      // R11: status 0x3D, sweep every mask
      pulse_ovr(); pulse_brk();
      cts_pin = 1'b1; txf_empty = 1'b0; tick(); tick();
      chk_stat("R11 status pattern A", 32'h3D);
      mask_sweep(6'h3D);

      // R11: status 0x02, sweep every mask
      wr(STAT, 32'h0);
      pulse_frm();
      cts_pin = 1'b0; txf_free = 1'b0; txf_empty = 1'b1; tick(); tick();
      chk_stat("R11 status pattern B", 32'h02);
      mask_sweep(6'h02);

      report();
   end
endmodule